// File: doc/BRIEF.md
# Cascaded Two-Channel Free-Running Counter

This block forms one wide free-running count out of two narrow up-counting channels. The low channel advances on each prescale tick while it is running. From its own count it produces a square wave: the wave is driven high when the low count reaches a "set" compare value and driven low when it reaches a "clear" compare value. With the default values of 0 and half-range, the duty cycle is 50%. The high channel takes no carry from the low channel. It counts the rising edges of that square wave, detected with a registered edge detector in the single system clock domain. It therefore advances once per low-channel wrap.

Each channel has its own start and stop strobes. A single synchronous clear strobe zeroes both channels in the same clock cycle. The concatenated value, high count above low count, is offered as a convenience output for a reader. Neither channel is reloaded by a compare match; both simply wrap.

Top module: `chain_counter`

## Requirements
- R1: After reset, both counts are 0, the wave output is high, and both channels are stopped, so ticks alone do not move the low count.
- R2: While the low channel runs, each cycle with `tick` high advances the low count by exactly one, wrapping from all-ones to 0. Cycles with `tick` low leave it unchanged.
- R3: The wave output becomes 1 in the cycle the low count becomes the set value (default 0). It becomes 0 in the cycle the low count becomes the clear value (default 0x8000). With the defaults, the wave is high exactly while the low count is below the clear value.
- R4: While the high channel runs, the high count increments by one in the clock cycle after a rising edge of the wave output, and wraps freely.
- R5: A `syncClr` pulse makes both counts 0 and the wave high on the next clock edge, whether or not the channels run. It takes precedence over a tick or wave edge in the same cycle, and that wave transition produces no high-channel increment.
- R6: A start or stop strobe changes a channel's running state at the next clock edge. A stopped channel holds its count.
- R7: When start and stop for the same channel are high in the same cycle, the channel ends up stopped.
- R8: `fullCount` equals the high count shifted left by the channel width, ORed with the low count.
- R9: The high channel ignores ticks and low-channel wraps while it is stopped. A wave rising edge that occurs while it is stopped is never counted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable for the low channel |
| syncClr | input | 1 | Synchronous clear of both channels |
| loStart | input | 1 | Start strobe, low channel |
| loStop | input | 1 | Stop strobe, low channel |
| hiStart | input | 1 | Start strobe, high channel |
| hiStop | input | 1 | Stop strobe, high channel |
| loCount | output | CNT_W | Low channel count |
| hiCount | output | CNT_W | High channel count |
| waveOut | output | 1 | Low channel square wave |
| fullCount | output | 2*CNT_W | Concatenated high and low counts |

## Verification
The assertions assume that the set and clear compare values differ and both fit in the channel width. They also assume that strobes and ticks are synchronous, single-cycle-sampled levels with no meaning outside a clocked edge. The bench uses a narrow channel width with set value 0 and clear value at half range. All stimulus is changed on the falling clock edge, so every input is stable across the sampling edge. Ticks come from a shift-register pattern mixed with continuous runs. This lets both channels wrap many times, and places stop, start and clear strobes on and around wave edges.

// File: rtl/chain_pkg.sv
package chain_pkg;
  // Strobes passed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic clr;     // synchronous clear of both channels
    logic loStep;  // low channel advances this cycle
    logic hiRun;   // high channel may count a wave edge this cycle
  } chainStrobe_t;
endpackage

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         syncClr,
  input  logic         loStart,
  input  logic         loStop,
  input  logic         hiStart,
  input  logic         hiStop,
  output chainStrobe_t strobe
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] startV;
  logic [NUM_CH-1:0] stopV;
  logic [NUM_CH-1:0] runQ;

  assign startV = {hiStart, loStart};
  assign stopV  = {hiStop, loStop};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           runQ[ch] <= 1'b0;
      else if (stopV[ch])  runQ[ch] <= 1'b0;   // stop wins over start
      else if (startV[ch]) runQ[ch] <= 1'b1;
    end

    // R7: a stop strobe always leaves the channel stopped
    assert_stop_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      stopV[ch] |=> !runQ[ch]);
    // R6: a lone start strobe leaves the channel running
    assert_start_runs_R6: assert property (@(posedge clk) disable iff (!rstN)
      startV[ch] && !stopV[ch] |=> runQ[ch]);
  end

  always_comb begin
    strobe.clr    = syncClr;
    strobe.loStep = runQ[0] & tick;
    strobe.hiRun  = runQ[1];
  end
endmodule

// File: rtl/chain_dp.sv
module chain_dp
  import chain_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SET_VAL = 0,
  parameter int CLR_VAL = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainStrobe_t     strobe,
  output logic [CNT_W-1:0] loCount,
  output logic [CNT_W-1:0] hiCount,
  output logic             waveOut
);
  localparam logic [CNT_W-1:0] SET_V     = CNT_W'(SET_VAL);
  localparam logic [CNT_W-1:0] CLR_V     = CNT_W'(CLR_VAL);
  localparam logic             WAVE_INIT = (SET_VAL == 0);

  logic [CNT_W-1:0] loNext;
  logic             wavePrev;
  logic             hiStep;

  always_comb begin
    loNext = loCount + 1'b1;
    hiStep = strobe.hiRun & waveOut & ~wavePrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loCount  <= '0;
      hiCount  <= '0;
      waveOut  <= WAVE_INIT;
      wavePrev <= WAVE_INIT;
    end else if (strobe.clr) begin
      loCount  <= '0;
      hiCount  <= '0;
      waveOut  <= WAVE_INIT;
      wavePrev <= WAVE_INIT;
    end else begin
      wavePrev <= waveOut;
      if (strobe.loStep) begin
        loCount <= loNext;
        if (loNext == SET_V)      waveOut <= 1'b1;
        else if (loNext == CLR_V) waveOut <= 1'b0;
      end
      if (hiStep) hiCount <= hiCount + 1'b1;
    end
  end

  // R2: a step advances the low count by one
  assert_lo_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loStep && !strobe.clr |=> loCount == CNT_W'($past(loCount) + 1'b1));
  // R6: no step, no change
  assert_lo_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loStep && !strobe.clr |=> $stable(loCount));
  // R3: wave level agrees with compare points
  assert_wave_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    loCount == SET_V |-> waveOut);
  assert_wave_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    loCount == CLR_V |-> !waveOut);
  // R9: a stopped high channel holds
  assert_hi_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hiRun && !strobe.clr |=> $stable(hiCount));
  // R4: high channel moves by at most one
  assert_hi_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clr |=> hiCount == $past(hiCount) || hiCount == CNT_W'($past(hiCount) + 1'b1));
  // R5: clear zeroes both channels
  assert_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> loCount == '0 && hiCount == '0);
endmodule

// File: rtl/chain_counter.sv
module chain_counter
  import chain_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SET_VAL = 0,
  parameter int CLR_VAL = 32768
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               syncClr,
  input  logic               loStart,
  input  logic               loStop,
  input  logic               hiStart,
  input  logic               hiStop,
  output logic [CNT_W-1:0]   loCount,
  output logic [CNT_W-1:0]   hiCount,
  output logic               waveOut,
  output logic [2*CNT_W-1:0] fullCount
);
  chainStrobe_t strobe;

  chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .syncClr(syncClr),
    .loStart(loStart), .loStop(loStop), .hiStart(hiStart), .hiStop(hiStop),
    .strobe(strobe)
  );

  chain_dp #(.CNT_W(CNT_W), .SET_VAL(SET_VAL), .CLR_VAL(CLR_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loCount(loCount), .hiCount(hiCount), .waveOut(waveOut)
  );

  assign fullCount = {hiCount, loCount};

  // R8: concatenation keeps halves in place
  assert_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullCount[CNT_W-1:0] == loCount && fullCount[2*CNT_W-1:CNT_W] == hiCount);
endmodule

// File: tb/sim_chain_counter.sv
module sim_chain_counter;
  localparam int PERIOD = 10;
  localparam int W = 4;
  localparam int CLRV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, syncClr = 1'b0;
  logic loStart = 1'b0, loStop = 1'b0, hiStart = 1'b0, hiStop = 1'b0;
  logic [W-1:0] loCount, hiCount;
  logic waveOut;
  logic [2*W-1:0] fullCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side expected state
  int mLo = 0, mHi = 0;
  bit mWave = 1'b1, mPrev = 1'b1, mRun0 = 1'b0, mRun1 = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  chain_counter #(.CNT_W(W), .SET_VAL(0), .CLR_VAL(CLRV)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .syncClr(syncClr),
    .loStart(loStart), .loStop(loStop), .hiStart(hiStart), .hiStop(hiStop),
    .loCount(loCount), .hiCount(hiCount), .waveOut(waveOut), .fullCount(fullCount)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mLo = 0; mHi = 0; mWave = 1; mPrev = 1; mRun0 = 0; mRun1 = 0;
    end else begin
      bit rise;
      int nlo;
      rise = mRun1 && mWave && !mPrev;
      if (syncClr) begin
        mLo = 0; mHi = 0; mWave = 1; mPrev = 1;
      end else begin
        mPrev = mWave;
        if (mRun0 && tick) begin
          nlo = (mLo + 1) % (1 << W);
          mLo = nlo;
          if (nlo == 0) mWave = 1;
          else if (nlo == CLRV) mWave = 0;
        end
        if (rise) mHi = (mHi + 1) % (1 << W);
      end
      if (loStop) mRun0 = 0; else if (loStart) mRun0 = 1;
      if (hiStop) mRun1 = 0; else if (hiStart) mRun1 = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelChk();
    chk("R2 loCount", int'(loCount), mLo);
    chk("R3 waveOut", int'(waveOut), int'(mWave));
    chk("R4 hiCount", int'(hiCount), mHi);
    chk("R8 fullCount", int'(fullCount), (mHi << W) | mLo);
  endtask

  // one cycle: drive inputs at negedge, check after the next posedge (at following negedge)
  task automatic cyc(input bit t, input bit sc, input bit ls, input bit lp, input bit hs, input bit hp);
    tick = t; syncClr = sc; loStart = ls; loStop = lp; hiStart = hs; hiStop = hp;
    @(negedge clk);
    tick = 0; syncClr = 0; loStart = 0; loStop = 0; hiStart = 0; hiStop = 0;
    modelChk();
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int held;
    lfsr = 8'hA5;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 loCount", int'(loCount), 0);
    chk("R1 hiCount", int'(hiCount), 0);
    chk("R1 waveOut", int'(waveOut), 1);
    // R1: channels stopped, ticks ignored
    repeat (3) cyc(1, 0, 0, 0, 0, 0);
    chk("R1 stopped loCount", int'(loCount), 0);
    // start low channel, continuous ticks through several wraps
    cyc(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0, 0, 0);
    chk("R9 hi stopped through wraps", int'(hiCount), 0);
    chk("R2 lo after 40 ticks", int'(loCount), 40 % 16);
    // start high channel, patterned ticks over many high wraps
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 700; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(lfsr[0] | lfsr[2], 0, 0, 0, 0, 0);
    end
    // R7: start and stop together leaves low channel stopped
    cyc(0, 0, 1, 1, 0, 0);
    held = int'(loCount);
    repeat (5) cyc(1, 0, 0, 0, 0, 0);
    chk("R7 lo held after start+stop", int'(loCount), held);
    // R9: stop high, run low across a wrap, restart high: edge not counted later
    cyc(0, 0, 1, 0, 0, 1);
    held = int'(hiCount);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    chk("R9 missed edge", int'(hiCount), held);
    // R4: next wrap counts, one cycle after the rise
    while (loCount != 4'hF) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 before increment", int'(hiCount), held);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R4 after increment", int'(hiCount), (held + 1) % 16);
    // R5: clear together with tick, on a rising wave edge
    while (loCount != 4'hF) cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R5 lo cleared", int'(loCount), 0);
    chk("R5 hi cleared", int'(hiCount), 0);
    chk("R5 wave high", int'(waveOut), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R5 no stray increment", int'(hiCount), 0);
    // R6: stop low, ticks hold count
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    held = int'(loCount);
    repeat (4) cyc(1, 0, 0, 0, 0, 0);
    chk("R6 stopped lo holds", int'(loCount), held);
    // R5: clear works while stopped
    cyc(0, 1, 0, 0, 0, 0);
    chk("R5 clear while stopped", int'(loCount), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule